// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an asynchronous static RAM of 64K words by 24 bits. The host hands over one word at a time through a request/acknowledge handshake. The controller then produces the active-low chip select, write enable and output enable strobes in the order the RAM needs. It also presents a stable 16-bit address and drives the 24-bit data bus through a separately enabled output driver.

All of the RAM's minimum timings are parameters counted in whole clock cycles. There is a setup count before the write pulse, a width for the write pulse, a hold count after the pulse, a wait count for read access and a turnaround count after a read. Writes are ended by the rising edge of write enable while chip select stays low. Reads hold chip select and output enable low for the access window. The word is captured on the last cycle of that window, and the bus is then left idle before the controller may drive it again.

The controller accepts one request at a time. It returns read data together with a one-cycle completion pulse. Address bit 15 is passed through unchanged, so the RAM can use it to select one of its two 32K halves.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, chip select, write enable and output enable are high, and the bus driver enable, acknowledge and done are low.
- R2: A write keeps chip select low with write enable high for T_SETUP cycles. It then drives write enable low for exactly T_PULSE cycles, and keeps write enable high with chip select low for T_HOLD cycles. On the next cycle chip select is high and done pulses.
- R3: While chip select is low, the address and the driven data word do not change, even if the host inputs change.
- R4: A read holds chip select and output enable low with write enable high for exactly T_RDWAIT cycles. It then raises all strobes for T_TURN cycles, and done pulses on the cycle after that.
- R5: The bus driver enable is high only during write cycles. Output enable is high whenever the driver is enabled or write enable is low. The controller never drives the bus while the RAM drives it or during the one cycle the RAM needs to release it.
- R6: Acknowledge is a one-cycle pulse on the cycle after a request is taken. A request that is held high while a cycle is in progress is not taken again before done.
- R7: Done is a one-cycle pulse. On a read, the returned word appears with done and stays unchanged until the next read completes, even across writes.
- R8: The address reaches the RAM unchanged, with bit 15 included. Words at addresses that differ only in bit 15 therefore stay independent.
- R9: A word written to any address reads back unchanged, including addresses 0x0000, 0x7FFF, 0x8000 and 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request a RAM cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address |
| host_wdata | input | 24 | Write word |
| host_ack | output | 1 | Request taken (one-cycle pulse) |
| host_done | output | 1 | Cycle complete (one-cycle pulse) |
| host_rdata | output | 24 | Last word read |
| ram_addr | output | 16 | RAM address |
| ram_cs_n | output | 1 | Chip select, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_dq_out | output | 24 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Enable for the data bus driver |
| ram_dq_in | input | 24 | Data seen on the RAM bus |

## Verification
The bench's RAM model returns garbage until the access window has fully elapsed. A controller that captures read data one cycle early therefore returns a wrong word. The model also keeps driving the bus for one cycle after output enable rises. A controller with too short a turnaround before a following write is then caught driving the bus at the same time as the RAM. A monitor measures every write pulse, setup and hold count, and every read window, so an off-by-one in the cycle timer shows up as a wrong width. Further checks cover a request held high through a busy cycle, host inputs that change mid-cycle, and pairs of addresses that differ only in bit 15. In these tests a controller that accepts the request twice, lets the address move while the cycle runs, or drops a bank bit loses or corrupts data.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RWAIT,
    ST_TURN
  } seq_state_t;

  function automatic int max_of5(input int a, input int b, input int c,
                                 input int d, input int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R2
  countdown_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int T_SETUP  = 2,
  parameter int T_PULSE  = 4,
  parameter int T_HOLD   = 1,
  parameter int T_RDWAIT = 5,
  parameter int T_TURN   = 2,
  parameter int CW       = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_we,
  input  logic          tmr_expired,
  output seq_state_t    state,
  output seq_state_t    nxt,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);

  localparam logic [CW-1:0] V_SETUP  = CW'(T_SETUP - 1);
  localparam logic [CW-1:0] V_PULSE  = CW'(T_PULSE - 1);
  localparam logic [CW-1:0] V_HOLD   = CW'(T_HOLD - 1);
  localparam logic [CW-1:0] V_RDWAIT = CW'(T_RDWAIT - 1);
  localparam logic [CW-1:0] V_TURN   = CW'(T_TURN - 1);

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (req) begin
        tmr_load = 1'b1;
        if (req_we) begin
          nxt     = ST_WSETUP;
          tmr_val = V_SETUP;
        end else begin
          nxt     = ST_RWAIT;
          tmr_val = V_RDWAIT;
        end
      end
      ST_WSETUP: if (tmr_expired) begin
        nxt      = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = V_PULSE;
      end
      ST_WPULSE: if (tmr_expired) begin
        nxt      = ST_WHOLD;
        tmr_load = 1'b1;
        tmr_val  = V_HOLD;
      end
      ST_WHOLD: if (tmr_expired) nxt = ST_IDLE;
      ST_RWAIT: if (tmr_expired) begin
        nxt      = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = V_TURN;
      end
      ST_TURN: if (tmr_expired) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !req) |=> (state == ST_IDLE));

  // R4
  read_then_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RWAIT && nxt != ST_RWAIT) |=> (state == ST_TURN));

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 24,
  parameter int T_SETUP  = 2,
  parameter int T_PULSE  = 4,
  parameter int T_HOLD   = 1,
  parameter int T_RDWAIT = 5,
  parameter int T_TURN   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ack,
  output logic          host_done,
  output logic [DW-1:0] host_rdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_cs_n,
  output logic          ram_we_n,
  output logic          ram_oe_n,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_in
);

  localparam int TMAX = max_of5(T_SETUP, T_PULSE, T_HOLD, T_RDWAIT, T_TURN);
  localparam int CW   = (TMAX > 1) ? $clog2(TMAX) : 1;

  seq_state_t    state, nxt;
  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val;

  sram_seq_fsm #(
    .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD),
    .T_RDWAIT(T_RDWAIT), .T_TURN(T_TURN), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst(rst), .req(host_req), .req_we(host_we),
    .tmr_expired(tmr_expired), .state(state), .nxt(nxt),
    .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  sram_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  logic accept, capture, finish, nxt_write, nxt_sel;

  assign accept    = (state == ST_IDLE) && host_req;
  assign capture   = (state == ST_RWAIT) && tmr_expired;
  assign finish    = ((state == ST_WHOLD) || (state == ST_TURN)) && tmr_expired;
  assign nxt_write = (nxt == ST_WSETUP) || (nxt == ST_WPULSE) || (nxt == ST_WHOLD);
  assign nxt_sel   = nxt_write || (nxt == ST_RWAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_cs_n   <= 1'b1;
      ram_we_n   <= 1'b1;
      ram_oe_n   <= 1'b1;
      ram_dq_oe  <= 1'b0;
      host_ack   <= 1'b0;
      host_done  <= 1'b0;
      ram_addr   <= '0;
      ram_dq_out <= '0;
      host_rdata <= '0;
    end else begin
      ram_cs_n  <= !nxt_sel;
      ram_we_n  <= (nxt != ST_WPULSE);
      ram_oe_n  <= (nxt != ST_RWAIT);
      ram_dq_oe <= nxt_write;
      host_ack  <= accept;
      host_done <= finish;
      if (accept) begin
        ram_addr   <= host_addr;
        ram_dq_out <= host_wdata;
      end
      if (capture) host_rdata <= ram_dq_in;
    end
  end

  // R5
  drive_vs_oe_chk: assert property (@(posedge clk) disable iff (rst)
    ram_dq_oe |-> ram_oe_n);

  // R5
  we_vs_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> ram_oe_n);

  // R2
  we_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> !ram_cs_n);

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!ram_cs_n && $past(!ram_cs_n)) |-> ($stable(ram_addr) && $stable(ram_dq_out)));

  // R6
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);

  // R4
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_oe_n) |-> ram_cs_n);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe && !host_ack && !host_done));

endmodule

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;

  localparam int AW = 16, DW = 24;
  localparam int T_SETUP = 2, T_PULSE = 4, T_HOLD = 1, T_RDWAIT = 5, T_TURN = 2;
  localparam logic [DW-1:0] GARBAGE = 24'hA5C3E1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          host_req = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_ack, host_done;
  logic [DW-1:0] host_rdata;
  logic [AW-1:0] ram_addr;
  logic          ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [DW-1:0] ram_dq_out, ram_dq_in;

  int checks = 0;
  int errors = 0;

  sram_seq_ctrl #(
    .AW(AW), .DW(DW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD),
    .T_RDWAIT(T_RDWAIT), .T_TURN(T_TURN)
  ) u_sram_seq_ctrl (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_done(host_done), .host_rdata(host_rdata), .ram_addr(ram_addr),
    .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // ---------------- RAM model: bit 15 picks a bank, three byte lanes each
  logic [7:0] lane_mem [int];
  function automatic int lane_key(input logic [AW-1:0] a, input int lane);
    return (int'(a[15]) << 17) | (lane << 15) | int'(a[14:0]);
  endfunction
  function automatic logic [DW-1:0] model_word(input logic [AW-1:0] a);
    logic [DW-1:0] w;
    for (int l = 0; l < 3; l++) begin
      int k;
      k = lane_key(a, l);
      w[l*8 +: 8] = lane_mem.exists(k) ? lane_mem[k] : 8'h00;
    end
    return w;
  endfunction

  logic read_sel, hz_tail, we_prev;
  int   acc;
  assign read_sel  = !ram_cs_n && !ram_oe_n && ram_we_n;
  assign ram_dq_in = (read_sel && acc >= T_RDWAIT) ? model_word(ram_addr) : GARBAGE;

  // ---------------- per-cycle monitor
  int we_low, setup_cnt, hold_cnt, oe_low;
  bit in_pulse_done;

  always @(negedge clk) begin
    if (rst) begin
      acc <= 0; hz_tail <= 1'b0; we_prev <= 1'b1;
      we_low <= 0; setup_cnt <= 0; hold_cnt <= 0; oe_low <= 0; in_pulse_done <= 1'b0;
    end else begin
      acc     <= read_sel ? acc + 1 : 0;
      hz_tail <= read_sel;
      we_prev <= ram_we_n;
      // R5: no overlap of controller drive with RAM drive or its release cycle
      if (ram_dq_oe && (read_sel || hz_tail))
        chk(1'b0, "R5", "bus contention", 32'(ram_dq_oe), 32'd0);
      if (!ram_we_n && !ram_oe_n)
        chk(1'b0, "R5", "oe low during write pulse", 32'(ram_oe_n), 32'd1);
      // model write on rising write enable with chip select low
      if (!we_prev && ram_we_n && !ram_cs_n) begin
        chk(ram_dq_oe, "R5", "driver off at write end", 32'(ram_dq_oe), 32'd1);
        for (int l = 0; l < 3; l++) lane_mem[lane_key(ram_addr, l)] = ram_dq_out[l*8 +: 8];
      end
      // R2 widths
      if (!ram_we_n) we_low <= we_low + 1;
      if (!ram_cs_n && ram_we_n && ram_oe_n && !in_pulse_done) setup_cnt <= setup_cnt + 1;
      if (!ram_cs_n && ram_we_n && in_pulse_done) hold_cnt <= hold_cnt + 1;
      if (we_prev && !ram_we_n) begin
        chk(setup_cnt == T_SETUP, "R2", "setup cycles", 32'(setup_cnt), 32'(T_SETUP));
      end
      if (!we_prev && ram_we_n) begin
        chk(we_low == T_PULSE, "R2", "pulse cycles", 32'(we_low), 32'(T_PULSE));
        we_low <= 0;
        in_pulse_done <= 1'b1;
        hold_cnt <= ram_cs_n ? 0 : 1;
      end
      if (ram_cs_n) begin
        if (in_pulse_done)
          chk(hold_cnt == T_HOLD, "R2", "hold cycles", 32'(hold_cnt), 32'(T_HOLD));
        in_pulse_done <= 1'b0; setup_cnt <= 0; hold_cnt <= 0;
      end
      // R4 read window
      if (!ram_oe_n) oe_low <= oe_low + 1;
      else if (oe_low != 0) begin
        chk(oe_low == T_RDWAIT, "R4", "read window", 32'(oe_low), 32'(T_RDWAIT));
        oe_low <= 0;
      end
    end
  end

  // ---------------- host tasks
  task automatic do_op(input bit we, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output logic [DW-1:0] rd);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    do @(negedge clk); while (!host_ack);
    host_req = 1'b0;
    do @(negedge clk); while (!host_done);
    rd = host_rdata;
  endtask

  logic [DW-1:0] shadow [int];
  function automatic logic [DW-1:0] expect_word(input logic [AW-1:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : '0;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] dummy;
    do_op(1'b1, a, d, dummy);
    shadow[int'(a)] = d;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string rq);
    logic [DW-1:0] got;
    do_op(1'b0, a, '0, got);
    chk(got == expect_word(a), rq, "readback", 32'(got), 32'(expect_word(a)));
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] tmp, held;
    int unsigned seed;
    seed = $urandom(32'h5EED_1730);

    repeat (3) @(negedge clk);
    // R1 reset values
    chk(ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe && !host_ack && !host_done,
        "R1", "reset strobes", {26'd0, ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe, host_ack, host_done},
        32'b111000);
    rst = 1'b0;
    @(negedge clk);
    chk(ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe, "R1", "after reset",
        {28'd0, ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe}, 32'b1110);

    // R2 R3 R6 directed write trace, request held and host inputs changed
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 16'h0003; host_wdata = 24'h123456;
    @(negedge clk);
    chk(host_ack, "R6", "ack after request", 32'(host_ack), 32'd1);
    host_addr = 16'h9999; host_wdata = 24'hFFFFFF;
    for (int i = 0; i < T_SETUP; i++) begin
      if (i != 0) @(negedge clk);
      chk(!ram_cs_n && ram_we_n && ram_oe_n && ram_dq_oe, "R2", "setup strobes",
          {28'd0, ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe}, 32'b0111);
    end
    for (int i = 0; i < T_PULSE; i++) begin
      @(negedge clk);
      chk(!ram_cs_n && !ram_we_n, "R2", "pulse strobes", {30'd0, ram_cs_n, ram_we_n}, 32'b00);
      chk(!host_ack, "R6", "no re-accept while busy", 32'(host_ack), 32'd0);
    end
    for (int i = 0; i < T_HOLD; i++) begin
      @(negedge clk);
      chk(!ram_cs_n && ram_we_n, "R2", "hold strobes", {30'd0, ram_cs_n, ram_we_n}, 32'b01);
      chk(ram_addr == 16'h0003 && ram_dq_out == 24'h123456, "R3", "address/data held",
          32'(ram_addr), 32'h0003);
    end
    @(negedge clk);
    chk(host_done && ram_cs_n && !ram_dq_oe, "R2", "write end",
        {29'd0, host_done, ram_cs_n, ram_dq_oe}, 32'b110);
    host_req = 1'b0;
    shadow[3] = 24'h123456;
    @(negedge clk);
    chk(!host_done, "R7", "done single cycle", 32'(host_done), 32'd0);
    chk(!host_ack && ram_cs_n, "R6", "held request not retaken", 32'(host_ack), 32'd0);

    // R4 R7 directed read trace
    host_req = 1'b1; host_we = 1'b0; host_addr = 16'h0003;
    @(negedge clk);
    host_req = 1'b0;
    for (int i = 0; i < T_RDWAIT; i++) begin
      if (i != 0) @(negedge clk);
      chk(!ram_cs_n && !ram_oe_n && ram_we_n && !ram_dq_oe, "R4", "read strobes",
          {28'd0, ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe}, 32'b0100);
    end
    for (int i = 0; i < T_TURN; i++) begin
      @(negedge clk);
      chk(ram_cs_n && ram_oe_n && ram_we_n && !ram_dq_oe && !host_done, "R4", "turnaround",
          {27'd0, ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe, host_done}, 32'b11100);
    end
    @(negedge clk);
    chk(host_done && host_rdata == 24'h123456, "R7", "read data with done",
        32'(host_rdata), 32'h123456);
    held = host_rdata;

    // R7 read data unaffected by a write
    wr(16'h0004, 24'h0BADF0);
    chk(host_rdata == held, "R7", "rdata held across write", 32'(host_rdata), 32'(held));

    // R8 bank pair, R9 boundaries
    wr(16'h0123, 24'hAAAA01);
    wr(16'h8123, 24'h5555FE);
    rd_chk(16'h0123, "R8");
    rd_chk(16'h8123, "R8");
    wr(16'h0000, 24'h000001);
    wr(16'hFFFF, 24'hFEDCBA);
    wr(16'h7FFF, 24'h7F7F7F);
    wr(16'h8000, 24'h808080);
    rd_chk(16'h0000, "R9");
    rd_chk(16'hFFFF, "R9");
    rd_chk(16'h7FFF, "R9");
    rd_chk(16'h8000, "R9");

    // R5 read immediately followed by write (turnaround under load)
    rd_chk(16'h0003, "R9");
    wr(16'h0003, 24'h3C3C3C);
    rd_chk(16'h0003, "R5");

    // random mix, R9
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = {1'($urandom % 2), 15'(($urandom % 8) * 4099)};
      if ($urandom % 2) wr(a, 24'($urandom));
      else begin
        do_op(1'b0, a, '0, tmp);
        chk(tmp == expect_word(a), "R9", "random readback", 32'(tmp), 32'(expect_word(a)));
      end
    end

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule